// File: doc/BRIEF.md
# Monitor Channel Receive Handshake

This block terminates the receive side of a byte-wide monitor channel carried once per frame on a time-division serial bus. It runs at frame granularity. Once per frame, a strobe tells it that the current monitor byte and the sender's active-low valid bit (`mx_n`) are ready to sample. The block answers by driving the active-low acknowledge bit (`mr_n`), which the bus logic returns to the sender in the next frame.

A byte counts as received only when the same value arrives in two consecutive frames while the valid bit is active. Acceptance lowers the acknowledge bit and gives a one-clock pulse with the byte. The sender then releases its valid bit for one frame, and the acknowledge bit is released in the next frame. If the valid bit comes back, another byte follows. If it stays released for a second frame, the message is over. When the valid bit is released before a byte has been acknowledged, the transfer is aborted.

The block also reports when the channel has gone quiet: both handshake bits released for two or more frames. Bit serialisation, frame alignment and any register access are handled elsewhere.

Top module: `mon_rx_hs`

## Requirements
- R1: After a synchronous active-high reset, `mr_n` is 1 and `byte_vld`, `eom`, `err` and `idle` are all 0.
- R2: When a byte value is seen with `mx_n`=0 in two consecutive frame strobes, starting from the idle or released state, `mr_n` goes to 0 and `byte_vld` pulses with `byte_out` equal to that value, both in the clock after the second strobe. This holds for any value, including 0xFF.
- R3: If consecutive bytes differ while `mx_n`=0, nothing is acknowledged. Comparison continues every frame, and the first later pair of equal bytes is accepted with that value.
- R4: After a byte is acknowledged, further frames with `mx_n`=0 keep `mr_n` at 0 and produce no new `byte_vld`.
- R5: The first strobe with `mx_n`=1 after an acknowledgement returns `mr_n` to 1 in the following clock.
- R6: If `mx_n` returns to 0 after a single released frame, the next byte again needs two matching frames before it is acknowledged.
- R7: A second consecutive strobe with `mx_n`=1 after an acknowledged byte pulses `eom` in the following clock and returns the block to idle.
- R8: A strobe with `mx_n`=1 while a byte is still unacknowledged pulses `err`, gives no acknowledgement, and returns to idle. A new message is then accepted normally.
- R9: `idle` becomes 1 after the second consecutive strobe at which both `mx_n` and `mr_n` are 1. It becomes 0 after any strobe at which either bit is 0.
- R10: Clocks without `frame_stb` leave every output unchanged, whatever `mx_n` and `mon_byte` do.
- R11: `byte_vld`, `eom` and `err` are each high for exactly one clock per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-clock pulse: this frame's monitor fields are valid |
| mx_n | input | 1 | Sender valid bit, active low |
| mon_byte | input | DW | Monitor byte of this frame |
| mr_n | output | 1 | Acknowledge bit to the sender, active low |
| byte_vld | output | 1 | One-clock pulse: new byte accepted |
| byte_out | output | DW | Last accepted byte |
| eom | output | 1 | One-clock pulse: end of message |
| idle | output | 1 | Channel quiet in this direction |
| err | output | 1 | One-clock pulse: transfer aborted |

## Verification
The bench sends a two-byte message with matching frame pairs. It then sends a pair whose first two bytes differ, which separates a design that acknowledges on any two active frames from one that compares the data. A byte of 0xFF is also sent, to show that the idle data value is not mistaken for silence. A release before acknowledgement is followed by a fresh message, which tells an abort from an end of message and confirms recovery. Between strobes, the valid bit and the data are scrambled, which exposes any logic that samples outside the frame strobe.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COLLECT  = 2'd1,
        ST_ACKED    = 2'd2,
        ST_RELEASED = 2'd3
    } hs_state_e;
endpackage

// File: rtl/mon_rx_cmp.sv
module mon_rx_cmp #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_stb,
    input  logic [DW-1:0] mon_byte,
    output logic          same_byte
);
    typedef struct packed {
        logic [DW-1:0] prev;
    } cmp_reg_t;

    cmp_reg_t r_d, r_q;

    // last frame's byte is kept every frame, valid bit active or not
    always_comb begin
        r_d = r_q;
        if (frame_stb) r_d.prev = mon_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{prev: '1};
        else     r_q <= r_d;
    end

    assign same_byte = (mon_byte == r_q.prev);
endmodule

// File: rtl/mon_rx_idle.sv
module mon_rx_idle #(
    parameter int QUIET_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_stb,
    input  logic mx_n,
    input  logic mr_n,
    output logic idle
);
    localparam int CW = $clog2(QUIET_FRAMES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUIET_FRAMES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          idle;
    } idle_reg_t;

    idle_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (frame_stb) begin
            if (mx_n && mr_n) begin
                if (r_q.cnt != LIMIT) r_d.cnt = r_q.cnt + 1'b1;
            end else begin
                r_d.cnt = '0;
            end
            r_d.idle = (r_d.cnt == LIMIT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{cnt: '0, idle: 1'b0};
        else     r_q <= r_d;
    end

    assign idle = r_q.idle;

    // R9: idle only rises after a strobe that saw both bits released
    a_r9_idle_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(idle) |-> ($past(frame_stb) && $past(mx_n) && $past(mr_n)));
    // R10: idle moves only after a strobe
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(idle) |-> $past(frame_stb));
endmodule

// File: rtl/mon_rx_fsm.sv
module mon_rx_fsm
    import mon_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_stb,
    input  logic          mx_n,
    input  logic [DW-1:0] mon_byte,
    input  logic          same_byte,
    output logic          mr_n,
    output logic          byte_vld,
    output logic [DW-1:0] byte_out,
    output logic          eom,
    output logic          err
);
    typedef struct packed {
        hs_state_e     st;
        logic          mr_n;
        logic          vld;
        logic [DW-1:0] data;
        logic          eom;
        logic          err;
    } fsm_reg_t;

    fsm_reg_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        r_d.eom = 1'b0;
        r_d.err = 1'b0;
        if (frame_stb) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.mr_n = 1'b1;
                    if (!mx_n) r_d.st = ST_COLLECT;
                end
                ST_COLLECT: begin
                    if (mx_n) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else if (same_byte) begin
                        r_d.mr_n = 1'b0;
                        r_d.vld  = 1'b1;
                        r_d.data = mon_byte;
                        r_d.st   = ST_ACKED;
                    end
                end
                ST_ACKED: begin
                    if (mx_n) begin
                        r_d.mr_n = 1'b1;
                        r_d.st   = ST_RELEASED;
                    end
                end
                ST_RELEASED: begin
                    if (mx_n) begin
                        r_d.eom = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.st = ST_COLLECT;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, mr_n: 1'b1, vld: 1'b0, data: '0,
                     eom: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mr_n     = r_q.mr_n;
    assign byte_vld = r_q.vld;
    assign byte_out = r_q.data;
    assign eom      = r_q.eom;
    assign err      = r_q.err;

    // R2: acceptance comes with the acknowledge bit active
    a_r2_vld_acks: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> !mr_n);
    // R2: accepted byte equals what was on the bus at the strobe
    a_r2_vld_data: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> (byte_out == $past(mon_byte) && !$past(mx_n)));
    // R7: end of message only with acknowledge released
    a_r7_eom_released: assert property (@(posedge clk) disable iff (rst)
        eom |-> mr_n);
    // R8: abort never acknowledges
    a_r8_err_no_ack: assert property (@(posedge clk) disable iff (rst)
        err |-> (mr_n && !byte_vld));
    // R10: acknowledge bit moves only after a strobe
    a_r10_mr_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(mr_n) |-> $past(frame_stb));
    // R11: pulses last one clock
    a_r11_one_clock: assert property (@(posedge clk) disable iff (rst)
        (byte_vld || eom || err) |=> !(byte_vld || eom || err));
endmodule

// File: rtl/mon_rx_hs.sv
module mon_rx_hs #(
    parameter int DW           = 8,
    parameter int QUIET_FRAMES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_stb,
    input  logic          mx_n,
    input  logic [DW-1:0] mon_byte,
    output logic          mr_n,
    output logic          byte_vld,
    output logic [DW-1:0] byte_out,
    output logic          eom,
    output logic          idle,
    output logic          err
);
    logic same_byte;

    mon_rx_cmp #(.DW(DW)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .mon_byte  (mon_byte),
        .same_byte (same_byte)
    );

    mon_rx_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .mx_n      (mx_n),
        .mon_byte  (mon_byte),
        .same_byte (same_byte),
        .mr_n      (mr_n),
        .byte_vld  (byte_vld),
        .byte_out  (byte_out),
        .eom       (eom),
        .err       (err)
    );

    mon_rx_idle #(.QUIET_FRAMES(QUIET_FRAMES)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .mx_n      (mx_n),
        .mr_n      (mr_n),
        .idle      (idle)
    );
endmodule

// File: tb/sim_mon_rx_hs.sv
`timescale 1ns/1ps
module sim_mon_rx_hs;
    localparam int DW = 8;
    localparam int EV_NONE = 0, EV_BYTE = 1, EV_EOM = 2, EV_ERR = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_stb = 1'b0;
    logic          mx_n = 1'b1;
    logic [DW-1:0] mon_byte = '1;
    logic          mr_n, byte_vld, eom, idle, err;
    logic [DW-1:0] byte_out;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int            kind;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    mon_rx_hs #(.DW(DW), .QUIET_FRAMES(2)) u0 (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .mx_n(mx_n),
        .mon_byte(mon_byte), .mr_n(mr_n), .byte_vld(byte_vld),
        .byte_out(byte_out), .eom(eom), .idle(idle), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected events as pulses appear
    always @(negedge clk) begin
        if (!rst && (byte_vld || eom || err)) begin
            int kind;
            kind = byte_vld ? EV_BYTE : (eom ? EV_EOM : EV_ERR);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", "unexpected event", kind, EV_NONE);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(kind == e.kind, e.tag, "event kind", kind, e.kind);
                if (e.kind == EV_BYTE)
                    chk(byte_out == e.data, e.tag, "byte_out", byte_out, e.data);
            end
        end
    end

    // driver: one frame, then scrambled inputs between strobes
    task automatic frame(input logic mx, input logic [DW-1:0] d,
                         input logic exp_mr, input logic exp_idle,
                         input int ev, input string tag);
        if (ev != EV_NONE) begin
            exp_t e;
            e.kind = ev; e.data = d; e.tag = tag;
            exp_q.push_back(e);
        end
        @(negedge clk);
        mx_n = mx; mon_byte = d; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        mx_n = ~mx; mon_byte = ~d;
        @(negedge clk);
        chk(exp_q.size() == 0, tag, "event pending", exp_q.size(), 0);
        chk(!(byte_vld || eom || err), "R11", "pulse width",
            {byte_vld, eom, err}, 0);
        mon_byte = d ^ 8'h5A;
        @(negedge clk);
        chk(mr_n == exp_mr, tag, "mr_n (R10 hold)", mr_n, exp_mr);
        chk(idle == exp_idle, tag, "idle", idle, exp_idle);
        exp_q.delete();
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mr_n == 1'b1, "R1", "reset mr_n", mr_n, 1);
        chk({byte_vld, eom, err, idle} == 4'b0, "R1", "reset flags",
            {byte_vld, eom, err, idle}, 0);

        // quiet channel
        frame(1'b1, 8'hFF, 1'b1, 1'b0, EV_NONE, "R9");
        frame(1'b1, 8'hFF, 1'b1, 1'b1, EV_NONE, "R9");
        // message with two bytes
        frame(1'b0, 8'h5A, 1'b1, 1'b0, EV_NONE, "R2");
        frame(1'b0, 8'h5A, 1'b0, 1'b0, EV_BYTE, "R2");
        frame(1'b0, 8'h5A, 1'b0, 1'b0, EV_NONE, "R4");
        frame(1'b1, 8'h5A, 1'b1, 1'b0, EV_NONE, "R5");
        frame(1'b0, 8'h3C, 1'b1, 1'b0, EV_NONE, "R6");
        frame(1'b0, 8'h3D, 1'b1, 1'b0, EV_NONE, "R3");
        frame(1'b0, 8'h3D, 1'b0, 1'b0, EV_BYTE, "R3");
        frame(1'b1, 8'hFF, 1'b1, 1'b0, EV_NONE, "R5");
        frame(1'b1, 8'hFF, 1'b1, 1'b0, EV_EOM,  "R7");
        frame(1'b1, 8'hFF, 1'b1, 1'b1, EV_NONE, "R9");
        // abort then recovery
        frame(1'b0, 8'h81, 1'b1, 1'b0, EV_NONE, "R8");
        frame(1'b1, 8'h81, 1'b1, 1'b0, EV_ERR,  "R8");
        frame(1'b0, 8'h42, 1'b1, 1'b0, EV_NONE, "R8");
        frame(1'b0, 8'h42, 1'b0, 1'b0, EV_BYTE, "R8");
        frame(1'b1, 8'hFF, 1'b1, 1'b0, EV_NONE, "R5");
        frame(1'b1, 8'hFF, 1'b1, 1'b0, EV_EOM,  "R7");
        frame(1'b1, 8'hFF, 1'b1, 1'b1, EV_NONE, "R9");
        // all-ones data byte
        frame(1'b0, 8'hFF, 1'b1, 1'b0, EV_NONE, "R2");
        frame(1'b0, 8'hFF, 1'b0, 1'b0, EV_BYTE, "R2");
        frame(1'b1, 8'hFF, 1'b1, 1'b0, EV_NONE, "R5");
        frame(1'b1, 8'hFF, 1'b1, 1'b0, EV_EOM,  "R7");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule